// File: doc/BRIEF.md
# Cache Line Coherence State Controller

This block holds the coherence state of every line in a four-way set-associative data cache. Each line has one of three states: invalid, valid or dirty. Each cycle the block takes at most one processor event and one snoop. The processor event arrives with the set and way it addresses and a flag that selects copyback or writethrough caching for that access. The block works out the next state of the addressed line, stores it, and returns that state one cycle later. With the state it returns two requests: one to allocate a line from memory and one to write the old contents back to memory.

Processor events are read hit, read miss, write hit, write miss, invalidate and push. For a miss, the way the processor names is the line that gets replaced. If that line is dirty, the block asks for a write-back together with the allocation. A snoop invalidates its line and returns the state the line held before. A snoop and a processor event can address the same line in the same cycle. In that case the snoop wins and the processor event is cancelled.

Top module: `line_state_ctrl`

## Requirements
- R1: After reset every line is invalid (code 2'b00) and both response valid outputs are low. States are coded 2'b00 invalid, 2'b01 valid and 2'b11 dirty. Code 2'b10 is never stored.
- R2: A read miss (event code 3'd1) raises the allocate request and leaves the line valid in either mode. The write-back request is raised exactly when the replaced line was dirty.
- R3: A copyback write miss (event 3'd3, copyback flag 1) raises the allocate request and leaves the line dirty. The write-back request is raised exactly when the replaced line was dirty.
- R4: A writethrough write miss (event 3'd3, copyback flag 0) raises no allocate or write-back request and leaves the line state unchanged, so an invalid line stays invalid.
- R5: A write hit (event 3'd2) turns a valid line dirty in copyback mode. In writethrough mode it leaves the line unchanged. It raises no request in either mode.
- R6: A read hit (event 3'd0) leaves the state unchanged, raises no request, and reports the current state. This makes it the way to observe a line.
- R7: An invalidate (event 3'd4) leaves the line invalid and raises no write-back, whatever the earlier state.
- R8: A push (event 3'd5) leaves the line invalid. It raises the write-back request exactly when the line was dirty, and never raises the allocate request.
- R9: A snoop leaves its line invalid and reports, one cycle later, the state the line held before. A snoop on an invalid line changes nothing.
- R10: When a snoop and a processor event address the same set and way in the same cycle, the processor response has its cancel flag set, reports invalid and raises no request. The line ends invalid.
- R11: Every accepted event produces its response on the cycle after the one in which it is presented. Back-to-back events to the same line each see the state the previous event left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor event present this cycle |
| cpu_evt | input | 3 | Processor event code (0 read hit, 1 read miss, 2 write hit, 3 write miss, 4 invalidate, 5 push) |
| cpu_set | input | SET_W | Set addressed by the processor event |
| cpu_way | input | WAY_W | Way addressed by the processor event (replaced line on a miss) |
| cpu_copyback | input | 1 | 1 selects copyback, 0 selects writethrough for this access |
| snp_valid | input | 1 | Snoop hit present this cycle |
| snp_set | input | SET_W | Set hit by the snoop |
| snp_way | input | WAY_W | Way hit by the snoop |
| rsp_valid | output | 1 | Processor response valid |
| rsp_state | output | 2 | New state of the addressed line |
| rsp_alloc | output | 1 | Request to fill the line from memory |
| rsp_wb | output | 1 | Request to write the old line contents back |
| rsp_kill | output | 1 | Processor event cancelled by a snoop to the same line |
| snp_rsp_valid | output | 1 | Snoop response valid |
| snp_rsp_prev | output | 2 | State the snooped line held before the snoop |

## Verification
A wrong stored state does not show at the ports when it is written. It shows when the same line is next touched. The next read hit on that line reports a wrong state code one cycle after it is issued. A later push or miss to that line also gives a wrong write-back request, which means dirty data is lost or an extra bus write is made. The bench keeps its own copy of every line's state and follows each state-changing event with a read hit or a dependent event to the same line. A stale or corrupted entry is therefore exposed at most two cycles after it is written. A long random run with overlapping snoops covers the collisions.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam logic [1:0] LS_INV   = 2'b00;
  localparam logic [1:0] LS_VAL   = 2'b01;
  localparam logic [1:0] LS_DIRTY = 2'b11;

  localparam logic [2:0] EV_RD_HIT  = 3'd0;
  localparam logic [2:0] EV_RD_MISS = 3'd1;
  localparam logic [2:0] EV_WR_HIT  = 3'd2;
  localparam logic [2:0] EV_WR_MISS = 3'd3;
  localparam logic [2:0] EV_INVAL   = 3'd4;
  localparam logic [2:0] EV_PUSH    = 3'd5;

  typedef struct packed {
    logic [1:0] nxt;
    logic       alloc;
    logic       wb;
  } xfer_t;

  function automatic logic st_dirty(input logic [1:0] s);
    return s[1] & s[0];
  endfunction

  function automatic logic st_present(input logic [1:0] s);
    return s[0];
  endfunction

  // Next state and bus requests for one processor event on one line.
  function automatic xfer_t cpu_xfer(input logic [2:0] ev,
                                     input logic [1:0] cur,
                                     input logic       cb);
    xfer_t r;
    r.nxt   = cur;
    r.alloc = 1'b0;
    r.wb    = 1'b0;
    case (ev)
      EV_RD_MISS: begin
        r.alloc = 1'b1;
        r.wb    = st_dirty(cur);
        r.nxt   = LS_VAL;
      end
      EV_WR_HIT: begin
        if (cb && st_present(cur)) r.nxt = LS_DIRTY;
      end
      EV_WR_MISS: begin
        if (cb) begin
          r.alloc = 1'b1;
          r.wb    = st_dirty(cur);
          r.nxt   = LS_DIRTY;
        end
      end
      EV_INVAL: r.nxt = LS_INV;
      EV_PUSH: begin
        r.wb  = st_dirty(cur);
        r.nxt = LS_INV;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsc_store.sv
module lsc_store #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_ridx,
  output logic [1:0]       cpu_rdat,
  input  logic [IDX_W-1:0] snp_ridx,
  output logic [1:0]       snp_rdat,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_widx,
  input  logic [1:0]       cpu_wdat,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_widx
);
  import lsc_pkg::*;

  localparam int NUM_LINES = 1 << IDX_W;

  logic [1:0] st_q [NUM_LINES];

  assign cpu_rdat = st_q[cpu_ridx];
  assign snp_rdat = st_q[snp_ridx];

  // Two write ports. The snoop port is written last, so it wins on a clash.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (cpu_we) st_q[cpu_widx] <= cpu_wdat;
      if (snp_we) st_q[snp_widx] <= LS_INV;
    end
  end

  // R1: the unused code must never be written into the state array
  a_r1_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |-> (cpu_wdat != 2'b10));

endmodule

// File: rtl/lsc_xfer.sv
module lsc_xfer (
  input  logic       ev_valid,
  input  logic [2:0] ev_code,
  input  logic [1:0] cur_state,
  input  logic       copyback,
  input  logic       kill,
  output logic       we,
  output logic [1:0] nxt_state,
  output logic       alloc,
  output logic       wb
);
  import lsc_pkg::*;

  xfer_t x;

  always_comb begin
    x  = cpu_xfer(ev_code, cur_state, copyback);
    we = ev_valid && !kill;
    if (kill) begin
      nxt_state = LS_INV;
      alloc     = 1'b0;
      wb        = 1'b0;
    end else begin
      nxt_state = x.nxt;
      alloc     = x.alloc;
      wb        = x.wb;
    end
  end

endmodule

// File: rtl/lsc_snoop.sv
module lsc_snoop #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [1:0]       snp_cur,
  input  logic             cpu_valid,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic             snp_we,
  output logic             cpu_kill,
  output logic             snp_rsp_valid,
  output logic [1:0]       snp_rsp_prev
);
  import lsc_pkg::*;

  assign snp_we   = snp_valid;
  assign cpu_kill = snp_valid && cpu_valid && (snp_idx == cpu_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_rsp_valid <= 1'b0;
      snp_rsp_prev  <= LS_INV;
    end else begin
      snp_rsp_valid <= snp_valid;
      snp_rsp_prev  <= snp_valid ? snp_cur : LS_INV;
    end
  end

  // R9: every snoop is answered on the following cycle
  a_r9_snoop_answered: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_rsp_valid);
  // R9: the reported prior state is the stored one seen at the snoop
  a_r9_prev_matches: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> (snp_rsp_prev == $past(snp_cur)));

endmodule

// File: rtl/line_state_ctrl.sv
module line_state_ctrl #(
  parameter int SET_W = 6,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic [2:0]       cpu_evt,
  input  logic [SET_W-1:0] cpu_set,
  input  logic [WAY_W-1:0] cpu_way,
  input  logic             cpu_copyback,
  input  logic             snp_valid,
  input  logic [SET_W-1:0] snp_set,
  input  logic [WAY_W-1:0] snp_way,
  output logic             rsp_valid,
  output logic [1:0]       rsp_state,
  output logic             rsp_alloc,
  output logic             rsp_wb,
  output logic             rsp_kill,
  output logic             snp_rsp_valid,
  output logic [1:0]       snp_rsp_prev
);
  import lsc_pkg::*;

  localparam int IDX_W = SET_W + WAY_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [1:0]       cpu_cur, snp_cur;
  logic             snp_we, cpu_kill;
  logic             cpu_we, nx_alloc, nx_wb;
  logic [1:0]       nx_state;

  assign cpu_idx = {cpu_set, cpu_way};
  assign snp_idx = {snp_set, snp_way};

  lsc_store #(.IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ridx (cpu_idx),
    .cpu_rdat (cpu_cur),
    .snp_ridx (snp_idx),
    .snp_rdat (snp_cur),
    .cpu_we   (cpu_we),
    .cpu_widx (cpu_idx),
    .cpu_wdat (nx_state),
    .snp_we   (snp_we),
    .snp_widx (snp_idx)
  );

  lsc_snoop #(.IDX_W(IDX_W)) u_snoop (
    .clk           (clk),
    .rst_n         (rst_n),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_idx),
    .snp_cur       (snp_cur),
    .cpu_valid     (cpu_valid),
    .cpu_idx       (cpu_idx),
    .snp_we        (snp_we),
    .cpu_kill      (cpu_kill),
    .snp_rsp_valid (snp_rsp_valid),
    .snp_rsp_prev  (snp_rsp_prev)
  );

  lsc_xfer u_xfer (
    .ev_valid  (cpu_valid),
    .ev_code   (cpu_evt),
    .cur_state (cpu_cur),
    .copyback  (cpu_copyback),
    .kill      (cpu_kill),
    .we        (cpu_we),
    .nxt_state (nx_state),
    .alloc     (nx_alloc),
    .wb        (nx_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_state <= LS_INV;
      rsp_alloc <= 1'b0;
      rsp_wb    <= 1'b0;
      rsp_kill  <= 1'b0;
    end else begin
      rsp_valid <= cpu_valid;
      rsp_state <= cpu_valid ? nx_state : LS_INV;
      rsp_alloc <= cpu_valid && nx_alloc;
      rsp_wb    <= cpu_valid && nx_wb;
      rsp_kill  <= cpu_kill;
    end
  end

  // R11: one response per event, one cycle later
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> rsp_valid);
  // R2: read miss allocates and leaves a valid line
  a_r2_rmiss_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_evt == EV_RD_MISS && !cpu_kill)
      |=> (rsp_alloc && rsp_state == LS_VAL));
  // R4: writethrough write miss makes no request
  a_r4_wt_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_evt == EV_WR_MISS && !cpu_copyback)
      |=> (!rsp_alloc && !rsp_wb));
  // R6: read hit keeps the stored state
  a_r6_rhit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_evt == EV_RD_HIT && !cpu_kill)
      |=> (rsp_state == $past(cpu_cur) && !rsp_alloc && !rsp_wb));
  // R7: invalidate never writes back
  a_r7_inval_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_evt == EV_INVAL) |=> (!rsp_wb && rsp_state == LS_INV));
  // R8: push writes back only a dirty line
  a_r8_push_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_evt == EV_PUSH && !cpu_kill)
      |=> (rsp_state == LS_INV && !rsp_alloc && rsp_wb == $past(cpu_cur == LS_DIRTY)));
  // R10: a snoop to the same line cancels the processor event
  a_r10_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid && cpu_idx == snp_idx)
      |=> (rsp_kill && !rsp_alloc && !rsp_wb && rsp_state == LS_INV));

endmodule

// File: tb/line_state_ctrl_tb.sv
module line_state_ctrl_tb;

  localparam int SW = 6;
  localparam int WW = 2;
  localparam int NL = 1 << (SW + WW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0;
  logic [2:0] cpu_evt = '0;
  logic [SW-1:0] cpu_set = '0;
  logic [WW-1:0] cpu_way = '0;
  logic cpu_copyback = 1'b0;
  logic snp_valid = 1'b0;
  logic [SW-1:0] snp_set = '0;
  logic [WW-1:0] snp_way = '0;
  logic rsp_valid, rsp_alloc, rsp_wb, rsp_kill, snp_rsp_valid;
  logic [1:0] rsp_state, snp_rsp_prev;

  always #4 clk = ~clk;

  line_state_ctrl #(.SET_W(SW), .WAY_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_evt(cpu_evt), .cpu_set(cpu_set),
    .cpu_way(cpu_way), .cpu_copyback(cpu_copyback),
    .snp_valid(snp_valid), .snp_set(snp_set), .snp_way(snp_way),
    .rsp_valid(rsp_valid), .rsp_state(rsp_state), .rsp_alloc(rsp_alloc),
    .rsp_wb(rsp_wb), .rsp_kill(rsp_kill),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_prev(snp_rsp_prev)
  );

  typedef struct packed {
    logic [1:0] st;
    logic alloc;
    logic wb;
    logic kill;
  } exp_t;

  int checks = 0;
  int errors = 0;
  logic [1:0] mdl [NL];
  exp_t exp_q [$];
  string exp_tag [$];
  logic [1:0] snp_q [$];
  string snp_tag [$];
  bit running = 1'b0;

  // Reference rule set: written as an independent decision list.
  function automatic exp_t model_cpu(input logic [2:0] ev, input logic [1:0] s, input logic cb);
    exp_t e;
    e.kill = 1'b0;
    if (ev == 3'd1) begin
      e.st = 2'b01; e.alloc = 1'b1; e.wb = (s == 2'b11);
    end else if (ev == 3'd3 && cb) begin
      e.st = 2'b11; e.alloc = 1'b1; e.wb = (s == 2'b11);
    end else if (ev == 3'd2 && cb && s != 2'b00) begin
      e.st = 2'b11; e.alloc = 1'b0; e.wb = 1'b0;
    end else if (ev == 3'd4) begin
      e.st = 2'b00; e.alloc = 1'b0; e.wb = 1'b0;
    end else if (ev == 3'd5) begin
      e.st = 2'b00; e.alloc = 1'b0; e.wb = (s == 2'b11);
    end else begin
      e.st = s; e.alloc = 1'b0; e.wb = 1'b0;
    end
    return e;
  endfunction

  task automatic fail_line(input string tag, input string what);
    errors++;
    $display("FAIL %s %s", tag, what);
  endtask

  // Driver: presents one cycle of stimulus and queues the expected results.
  task automatic step(input bit dc, input logic [2:0] ev, input int s, input int w,
                      input bit cb, input bit ds, input int ss, input int sw,
                      input string tag);
    int ci, si;
    exp_t e;
    @(negedge clk);
    ci = s * (1 << WW) + w;
    si = ss * (1 << WW) + sw;
    cpu_valid = dc; cpu_evt = ev; cpu_set = SW'(s); cpu_way = WW'(w); cpu_copyback = cb;
    snp_valid = ds; snp_set = SW'(ss); snp_way = WW'(sw);
    if (ds) begin
      snp_q.push_back(mdl[si]);
      snp_tag.push_back(tag);
    end
    if (dc) begin
      if (ds && ci == si) begin
        e.st = 2'b00; e.alloc = 1'b0; e.wb = 1'b0; e.kill = 1'b1;
      end else begin
        e = model_cpu(ev, mdl[ci], cb);
        mdl[ci] = e.st;
      end
      exp_q.push_back(e);
      exp_tag.push_back(tag);
    end
    if (ds) mdl[si] = 2'b00;
  endtask

  task automatic cpu(input logic [2:0] ev, input int s, input int w, input bit cb, input string tag);
    step(1'b1, ev, s, w, cb, 1'b0, 0, 0, tag);
  endtask

  task automatic snoop(input int s, input int w, input string tag);
    step(1'b0, 3'd0, 0, 0, 1'b0, 1'b1, s, w, tag);
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 0, 0, 1'b0, 1'b0, 0, 0, "idle");
  endtask

  // Monitor: pops and compares as responses appear.
  always @(negedge clk) begin
    if (running) begin
      if (rsp_valid) begin
        checks++;
        if (exp_q.size() == 0) fail_line("R11", "unexpected cpu response: got valid exp none");
        else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          if ({rsp_state, rsp_alloc, rsp_wb, rsp_kill} != e)
            fail_line(t, $sformatf("cpu rsp: got st=%b alloc=%b wb=%b kill=%b exp st=%b alloc=%b wb=%b kill=%b",
              rsp_state, rsp_alloc, rsp_wb, rsp_kill, e.st, e.alloc, e.wb, e.kill));
        end
      end
      if (snp_rsp_valid) begin
        checks++;
        if (snp_q.size() == 0) fail_line("R9", "unexpected snoop response: got valid exp none");
        else begin
          logic [1:0] p;
          string t;
          p = snp_q.pop_front();
          t = snp_tag.pop_front();
          if (snp_rsp_prev != p)
            fail_line(t, $sformatf("snoop prev: got %b exp %b", snp_rsp_prev, p));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: got hang exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) mdl[i] = 2'b00;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || snp_rsp_valid !== 1'b0)
      fail_line("R1", $sformatf("outputs in reset: got %b%b exp 00", rsp_valid, snp_rsp_valid));
    rst_n = 1'b1;
    running = 1'b1;

    cpu(3'd0, 0, 0, 1'b1, "R1");
    cpu(3'd0, 63, 3, 1'b0, "R1");
    cpu(3'd1, 1, 0, 1'b0, "R2");
    cpu(3'd0, 1, 0, 1'b0, "R6");
    cpu(3'd2, 1, 0, 1'b0, "R5");
    cpu(3'd2, 1, 0, 1'b1, "R5");
    cpu(3'd0, 1, 0, 1'b1, "R6");
    cpu(3'd3, 2, 1, 1'b0, "R4");
    cpu(3'd0, 2, 1, 1'b0, "R4");
    cpu(3'd3, 2, 1, 1'b1, "R3");
    cpu(3'd3, 2, 1, 1'b1, "R3");
    cpu(3'd1, 1, 0, 1'b0, "R2");
    cpu(3'd5, 1, 0, 1'b0, "R8");
    cpu(3'd3, 3, 2, 1'b1, "R3");
    cpu(3'd5, 3, 2, 1'b1, "R8");
    cpu(3'd5, 3, 2, 1'b1, "R8");
    cpu(3'd3, 4, 3, 1'b1, "R3");
    cpu(3'd4, 4, 3, 1'b1, "R7");
    cpu(3'd4, 4, 3, 1'b0, "R7");
    cpu(3'd0, 4, 3, 1'b0, "R7");
    cpu(3'd3, 5, 0, 1'b1, "R3");
    idle();
    snoop(5, 0, "R9");
    cpu(3'd0, 5, 0, 1'b1, "R9");
    snoop(5, 0, "R9");
    cpu(3'd1, 6, 0, 1'b0, "R11");
    step(1'b1, 3'd1, 7, 1, 1'b0, 1'b1, 6, 0, "R9");
    cpu(3'd0, 7, 1, 1'b0, "R11");
    cpu(3'd1, 8, 2, 1'b1, "R2");
    step(1'b1, 3'd2, 8, 2, 1'b1, 1'b1, 8, 2, "R10");
    cpu(3'd0, 8, 2, 1'b1, "R10");
    cpu(3'd1, 9, 3, 1'b1, "R2");
    step(1'b1, 3'd5, 9, 3, 1'b1, 1'b1, 9, 3, "R10");

    for (int n = 0; n < 3000; n++) begin
      bit ds;
      ds = ($urandom % 5) == 0;
      step(1'b1, 3'($urandom % 6), int'($urandom % 4), int'($urandom % 4), 1'($urandom),
           ds, int'($urandom % 4), int'($urandom % 4), "R11");
    end
    idle();
    idle();
    idle();
    checks++;
    if (exp_q.size() != 0 || snp_q.size() != 0)
      fail_line("R11", $sformatf("missing responses: got %0d left exp 0", exp_q.size() + snp_q.size()));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule